// File: doc/BRIEF.md
# Shared-Memory Fetch Stall Controller

This block holds the stall logic for a four-stage in-order pipeline whose stages run in the order fetch (IF), decode (ID), execute (IE) and result write (RW). Instruction fetch and the result-write stage share one memory port. A store in RW needs that port, so a fetch in the same cycle cannot be served. The controller settles this every cycle. RW always wins the port. The fetch is suppressed and the program counter holds its value. A bubble enters the decode stage while the older instructions keep moving toward RW. The fetch is retried in each later cycle until RW no longer holds a store.

The block tracks a valid bit and a store flag for each stage behind fetch. It keeps the program counter and a saturating count of suppressed fetch cycles. The surrounding pipeline supplies one input per cycle: whether the word being fetched is a store. That input is sampled only in a cycle where the fetch goes ahead. An instruction fetched in cycle t sits in ID in cycle t+1, in IE in cycle t+2 and in RW in cycle t+3. A store therefore blocks the fetch exactly three cycles after its own fetch.

Top module: `fetch_stall_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, idValid, ieValid, rwValid and rwIsStore are 0, stallCnt is 0 and pc is 0.
- R2: memSelRw is 1 (port to the result-write stage) exactly in the cycles where rwValid and rwIsStore are both 1. Otherwise it is 0 (port to fetch).
- R3: fetchEn is the inverse of memSelRw. pcHold and idBubble equal memSelRw in every cycle.
- R4: After a cycle with fetchEn=1, pc has advanced by PC_STEP (default 4), wrapping at PC_W bits. After a cycle with pcHold=1, pc is unchanged.
- R5: After a cycle with fetchEn=1, idValid is 1 and the decode-stage store flag equals the fetchIsStore value of that cycle. After a cycle with idBubble=1, idValid is 0.
- R6: In every cycle the execute stage takes the decode stage's valid bit and store flag, and RW takes the execute stage's. A stall does not hold them.
- R7: stallCnt rises by one after each cycle with fetchEn=0 and stops at 2^CNT_W-1 (255 by default). It never changes in a cycle with fetchEn=1.
- R8: When the first three instructions after reset are stores and the rest are not, the fourth fetch happens in cycle 7 (the first cycle after reset is cycle 1), and the fifth instruction is in RW in cycle 11.
- R9: A valid non-store instruction in RW does not block the fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| fetchIsStore | input | 1 | The word being fetched this cycle is a store; sampled only when fetchEn=1 |
| memSelRw | output | 1 | Memory port select: 1 gives the port to result write, 0 to fetch |
| fetchEn | output | 1 | The fetch proceeds this cycle |
| pcHold | output | 1 | The program counter keeps its value this cycle |
| idBubble | output | 1 | An empty slot enters decode at the next edge |
| pc | output | PC_W | Address of the instruction being fetched |
| idValid | output | 1 | Decode stage holds an instruction |
| ieValid | output | 1 | Execute stage holds an instruction |
| rwValid | output | 1 | Result-write stage holds an instruction |
| rwIsStore | output | 1 | The instruction in result write is a store |
| stallCnt | output | CNT_W | Saturating count of suppressed fetch cycles |

## Verification
The port select, fetch enable, PC hold and bubble strobe are combinational on the result-write stage. They are compared in the same cycle as the stage contents they depend on. The program counter, the stall count and the decode-stage valid bit move one edge after the cycle that decides them, the execute stage two edges after and result write three edges after. The bench keeps its own expected pipeline that advances once per edge. It samples every output at the falling edge and drives the next fetchIsStore only after that sample. In the three-store program, it also records the cycle numbers of the fourth fetch and of the fifth instruction reaching RW.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  // number of pipeline stages, fetch included; the RW stage is the last
  localparam int STAGES = 4;

  typedef struct packed {
    logic fetchGo;       // fetch proceeds and the PC advances
    logic portToRw;      // memory port belongs to the result-write stage
    logic holdPc;        // PC keeps its value
    logic injectBubble;  // an empty slot enters decode
  } strobe_t;

endpackage

// File: rtl/fsc_control.sv
module fsc_control
  import fsc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    rwValid,
  input  logic    rwIsStore,
  output strobe_t strb
);

  logic rwWantsMem;

  assign rwWantsMem = rwValid & rwIsStore;

  always_comb begin
    strb.portToRw     = rwWantsMem;
    strb.fetchGo      = ~rwWantsMem;
    strb.holdPc       = rwWantsMem;
    strb.injectBubble = rwWantsMem;
  end

  // R2
  port_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.portToRw && strb.fetchGo));

  // R9
  plain_rw_no_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rwValid && !rwIsStore) |-> strb.fetchGo);

endmodule

// File: rtl/fsc_datapath.sv
module fsc_datapath
  import fsc_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int CNT_W   = 8,
  parameter int PC_STEP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic             fetchIsStore,
  output logic [PC_W-1:0]  pc,
  output logic [CNT_W-1:0] stallCnt,
  output logic             idValid,
  output logic             ieValid,
  output logic             rwValid,
  output logic             rwIsStore
);

  localparam int LAST = STAGES - 1;
  localparam logic [PC_W-1:0]  STEP    = PC_W'(PC_STEP);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // index 1 = ID, 2 = IE, LAST = RW
  logic [LAST:1] vld;
  logic [LAST:1] sto;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld[1] <= 1'b0;
      sto[1] <= 1'b0;
    end else begin
      vld[1] <= strb.fetchGo;
      sto[1] <= strb.fetchGo & fetchIsStore;
    end
  end

  for (genvar k = 2; k <= LAST; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        vld[k] <= 1'b0;
        sto[k] <= 1'b0;
      end else begin
        vld[k] <= vld[k-1];
        sto[k] <= sto[k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc <= '0;
    end else if (!strb.holdPc) begin
      pc <= pc + STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallCnt <= '0;
    end else if (strb.holdPc && stallCnt != CNT_MAX) begin
      stallCnt <= stallCnt + 1'b1;
    end
  end

  assign idValid   = vld[1];
  assign ieValid   = vld[2];
  assign rwValid   = vld[LAST];
  assign rwIsStore = sto[LAST];

  // R4
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.holdPc |=> $stable(pc));

  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fetchGo |=> pc == $past(pc) + STEP);

  // R5
  bubble_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.injectBubble |=> !idValid);

  // R6
  advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (rwValid == $past(ieValid)));

  // R7
  cnt_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.holdPc && stallCnt != CNT_MAX) |=> stallCnt == $past(stallCnt) + 1'b1);

  // R7
  cnt_still_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fetchGo |=> $stable(stallCnt));

endmodule

// File: rtl/fetch_stall_ctrl.sv
module fetch_stall_ctrl
  import fsc_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int CNT_W   = 8,
  parameter int PC_STEP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchIsStore,
  output logic             memSelRw,
  output logic             fetchEn,
  output logic             pcHold,
  output logic             idBubble,
  output logic [PC_W-1:0]  pc,
  output logic             idValid,
  output logic             ieValid,
  output logic             rwValid,
  output logic             rwIsStore,
  output logic [CNT_W-1:0] stallCnt
);

  strobe_t strb;

  fsc_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rwValid   (rwValid),
    .rwIsStore (rwIsStore),
    .strb      (strb)
  );

  fsc_datapath #(
    .PC_W    (PC_W),
    .CNT_W   (CNT_W),
    .PC_STEP (PC_STEP)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .fetchIsStore (fetchIsStore),
    .pc           (pc),
    .stallCnt     (stallCnt),
    .idValid      (idValid),
    .ieValid      (ieValid),
    .rwValid      (rwValid),
    .rwIsStore    (rwIsStore)
  );

  assign memSelRw = strb.portToRw;
  assign fetchEn  = strb.fetchGo;
  assign pcHold   = strb.holdPc;
  assign idBubble = strb.injectBubble;

endmodule

// File: tb/sim_fetch_stall_ctrl.sv
module sim_fetch_stall_ctrl;

  localparam int PC_W  = 16;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             fetchIsStore = 1'b0;
  logic             memSelRw, fetchEn, pcHold, idBubble;
  logic [PC_W-1:0]  pc;
  logic             idValid, ieValid, rwValid, rwIsStore;
  logic [CNT_W-1:0] stallCnt;

  int checks = 0;
  int fails  = 0;

  // bench-side expected pipeline
  logic             mIdV, mIdS, mIeV, mIeS, mRwV, mRwS;
  logic [PC_W-1:0]  mPc;
  int               mCnt;
  int               mFetched;
  int               cycleNo;
  int               fetchCycle [0:7];
  int               retireCycle[0:7];
  int               retired;
  logic [31:0]      progMask;
  logic             tailStore;

  fetch_stall_ctrl #(.PC_W(PC_W), .CNT_W(CNT_W), .PC_STEP(4)) u0 (
    .clk(clk), .rstN(rstN), .fetchIsStore(fetchIsStore),
    .memSelRw(memSelRw), .fetchEn(fetchEn), .pcHold(pcHold), .idBubble(idBubble),
    .pc(pc), .idValid(idValid), .ieValid(ieValid), .rwValid(rwValid),
    .rwIsStore(rwIsStore), .stallCnt(stallCnt)
  );

  always #2 clk = ~clk;   // 250 MHz

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    fetchIsStore = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state held in reset
    check("R1", "rwValid in reset", int'(rwValid), 0);
    check("R1", "pc in reset", int'(pc), 0);
    rstN = 1'b1;
    mIdV = 0; mIdS = 0; mIeV = 0; mIeS = 0; mRwV = 0; mRwS = 0;
    mPc = '0; mCnt = 0; mFetched = 0; cycleNo = 0; retired = 0;
    for (int i = 0; i < 8; i++) begin
      fetchCycle[i] = 0;
      retireCycle[i] = 0;
    end
  endtask

  // one cycle: compare at the falling edge, drive, advance model
  task automatic stepCycle();
    logic busy;
    logic nextStore;
    cycleNo++;
    busy = mRwV & mRwS;
    check("R2", "memSelRw", int'(memSelRw), int'(busy));
    check("R3", "fetchEn", int'(fetchEn), int'(!busy));
    check("R3", "pcHold", int'(pcHold), int'(busy));
    check("R3", "idBubble", int'(idBubble), int'(busy));
    check("R4", "pc", int'(pc), int'(mPc));
    check("R5", "idValid", int'(idValid), int'(mIdV));
    check("R6", "ieValid", int'(ieValid), int'(mIeV));
    check("R6", "rwValid", int'(rwValid), int'(mRwV));
    check("R6", "rwIsStore", int'(rwIsStore), int'(mRwS));
    check("R7", "stallCnt", int'(stallCnt), mCnt);
    if (mRwV) begin
      if (retired < 8) retireCycle[retired] = cycleNo;
      retired++;
    end
    nextStore = (mFetched < 32) ? progMask[mFetched] : tailStore;
    fetchIsStore = nextStore;
    mRwV = mIeV; mRwS = mIeS;
    mIeV = mIdV; mIeS = mIdS;
    if (busy) begin
      mIdV = 0; mIdS = 0;
      if (mCnt < (1 << CNT_W) - 1) mCnt++;
    end else begin
      if (mFetched < 8) fetchCycle[mFetched] = cycleNo;
      mIdV = 1; mIdS = nextStore;
      mPc = mPc + 16'd4;
      mFetched++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runProg(input logic [31:0] mask, input logic tail, input int n);
    progMask = mask;
    tailStore = tail;
    doReset();
    // R1: first cycle after reset
    check("R1", "idValid after reset", int'(idValid), 0);
    check("R1", "stallCnt after reset", int'(stallCnt), 0);
    for (int i = 0; i < n; i++) stepCycle();
  endtask

  task automatic testNoStores();
    runProg(32'h0, 1'b0, 24);
    // R9: non-stores in RW never stall
    check("R9", "no stall with plain results", int'(stallCnt), 0);
    check("R4", "pc after 24 fetches", int'(pc), 24 * 4);
  endtask

  task automatic testSingleStore();
    runProg(32'h4, 1'b0, 16);
    // store fetched in cycle 3, blocks fetch in cycle 6 only
    check("R2", "single store stall count", int'(stallCnt), 1);
  endtask

  task automatic testThreeStores();
    runProg(32'h7, 1'b0, 12);
    // R8
    check("R8", "fourth fetch cycle", fetchCycle[3], 7);
    check("R8", "fifth retire cycle", retireCycle[4], 11);
    check("R8", "stall cycles", int'(stallCnt), 3);
  endtask

  task automatic testMixed();
    runProg(32'hA5C3_19E6, 1'b0, 60);
  endtask

  task automatic testSaturate();
    runProg(32'hFFFF_FFFF, 1'b1, 560);
    // R7: counter stops at its top value
    check("R7", "saturated stallCnt", int'(stallCnt), (1 << CNT_W) - 1);
  endtask

  initial begin
    @(negedge clk);
    testNoStores();
    testSingleStore();
    testThreeStores();
    testMixed();
    testSaturate();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule